// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block sits between a processor's load/store port and a slower, word-addressed main memory. It holds sixteen lines of four 32-bit words, indexed directly by the word address, so each address has exactly one place it can live. Loads that find their line present return data in the same cycle with no stall. Loads that miss stall the processor while the whole line is read from memory. The requested word is fetched last and is forwarded straight to the processor in the cycle it arrives.

Every store goes to memory. The store request leaves the block in the same cycle the processor presents it, without waiting for the tag compare. A store that hits also updates the cached word when memory acknowledges it. A store that misses first completes its memory write and then reads the line in, so the line is valid afterwards and already holds the new word.

The memory side uses a request/acknowledge handshake. A request holds its address, direction and data steady until the acknowledge. With a memory that acknowledges in the second cycle of each request, a read miss costs eight stall cycles, a store miss nine, and a store hit one.

Top module: `wt_dcache`

## Requirements
- R1: The 8-bit word address splits into tag = bits [7:6], line index = bits [5:2] and word offset = bits [1:0]. Two addresses with the same index and different tags evict each other, so alternating reads of them miss every time.
- R2: After reset no line is valid and `cpu_stall` and `mem_req` are low while no access is presented. The first read of any address after reset is a miss.
- R3: A read that hits, with no store strobe, keeps `cpu_stall` low and `mem_req` low, and returns the cached word on `cpu_rdata` in the same cycle.
- R4: With a memory that raises `mem_ack` in the second cycle of each request, a read miss holds `cpu_stall` high for exactly 8 consecutive cycles. In the cycle `cpu_stall` falls, `cpu_rdata` carries the memory word at the requested address.
- R5: A line fill issues four word reads (`mem_we` = 0). It starts at offset+1 of the requested word and wraps within the line, so the requested word is fetched last. All four words of the line then hit.
- R6: Every store drives `mem_req` = 1 and `mem_we` = 1, with `mem_addr` and `mem_wdata` equal to the processor's address and data, in the very cycle the store is presented. Memory then holds the stored word.
- R7: A store that hits holds `cpu_stall` high for exactly 1 cycle, and a later read of that address hits and returns the new word.
- R8: A store that misses holds `cpu_stall` high for exactly 9 cycles. Afterwards the whole line is valid: the stored word and its neighbours hit and return memory's contents.
- R9: Once `mem_req` is raised, it and `mem_addr`, `mem_we` (and `mem_wdata` for writes) stay unchanged until the cycle `mem_ack` is seen.
- R10: When `cpu_rd` and `cpu_wr` are both high, the access is handled as a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 8 | Processor word address, held while stalled |
| cpu_rd | input | 1 | Load strobe |
| cpu_wr | input | 1 | Store strobe (wins over load) |
| cpu_wdata | input | 32 | Store data, held while stalled |
| cpu_rdata | output | 32 | Load data, valid when `cpu_rd` is high and `cpu_stall` is low |
| cpu_stall | output | 1 | Processor must hold its access while high |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a memory write, 0 for a read |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge, one cycle per request |

## Verification
A stale tag or valid bit shows up as a wrong stall length on the very next access to that index: 0 cycles where 8 are due, or the reverse. A load that wrongly hits returns a word that differs from the bench's memory copy in the same cycle. A fill that writes the wrong offset, or a store hit that skips the array update, stays hidden until that word is read back. For that reason the random stimulus confines addresses to a few indices and tags, so words are re-read soon after they change. A broken write-through path shows in the first cycle of the store on the memory pins, and in the memory copy once the store ends.

// File: rtl/dc_pkg.sv
package dc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_FILL  = 2'd2
  } dc_state_e;

  localparam int unsigned DC_TAG_W  = 2;
  localparam int unsigned DC_IDX_W  = 4;
  localparam int unsigned DC_OFF_W  = 2;
  localparam int unsigned DC_DATA_W = 32;

endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int unsigned TAG_W = 2,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag
);

  localparam int unsigned LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] valid_d;
  logic [TAG_W-1:0] tag_q [LINES];

  // next state of the valid vector
  always_comb begin
    valid_d = valid_q;
    if (set_en) begin
      valid_d[set_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // one clock-enabled tag register per line, no reset needed
  for (genvar g = 0; g < LINES; g++) begin : g_tag
    logic tag_en;
    assign tag_en = set_en && (set_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (tag_en) begin
        tag_q[g] <= set_tag;
      end
    end
  end

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (valid_q == '0)); // R2

endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned OFF_W  = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned SLOTS  = 1 << (IDX_W + OFF_W);
  localparam int unsigned SLOT_W = IDX_W + OFF_W;

  logic [DATA_W-1:0] word_q [SLOTS];
  logic [SLOT_W-1:0] wr_slot;
  logic [SLOT_W-1:0] rd_slot;

  assign wr_slot = {wr_idx, wr_off};
  assign rd_slot = {rd_idx, rd_off};

  // per-word clock enable, storage is not reset
  for (genvar s = 0; s < SLOTS; s++) begin : g_word
    logic word_en;
    assign word_en = wr_en && (wr_slot == SLOT_W'(s));
    always_ff @(posedge clk) begin
      if (word_en) begin
        word_q[s] <= wr_data;
      end
    end
  end

  assign rd_data = word_q[rd_slot];

endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int unsigned TAG_W  = 2,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned OFF_W  = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TAG_W+IDX_W+OFF_W-1:0]  cpu_addr,
  input  logic                          cpu_rd,
  input  logic                          cpu_wr,
  input  logic [DATA_W-1:0]             cpu_wdata,
  input  logic                          lk_hit,
  input  logic                          mem_ack,
  input  logic [DATA_W-1:0]             mem_rdata,
  output logic                          cpu_stall,
  output logic                          rd_fwd,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [TAG_W+IDX_W+OFF_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]             mem_wdata,
  output logic                          line_set,
  output logic [IDX_W-1:0]              line_idx,
  output logic [TAG_W-1:0]              line_tag,
  output logic                          dw_en,
  output logic [IDX_W-1:0]              dw_idx,
  output logic [OFF_W-1:0]              dw_off,
  output logic [DATA_W-1:0]             dw_data
);

  localparam int unsigned ADDR_W = TAG_W + IDX_W + OFF_W;

  dc_state_e         st_q, st_d;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              whit_q;
  logic              cap_en;

  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [OFF_W-1:0]  off_q;
  logic [IDX_W-1:0]  cpu_idx;
  logic [OFF_W-1:0]  cpu_off;
  logic [OFF_W-1:0]  fill_off;
  logic              last_beat;

  assign tag_q     = addr_q[ADDR_W-1 -: TAG_W];
  assign idx_q     = addr_q[OFF_W +: IDX_W];
  assign off_q     = addr_q[OFF_W-1:0];
  assign cpu_idx   = cpu_addr[OFF_W +: IDX_W];
  assign cpu_off   = cpu_addr[OFF_W-1:0];
  // fill starts one past the requested word and wraps, requested word last
  assign fill_off  = off_q + OFF_W'(1) + cnt_q;
  assign last_beat = &cnt_q;

  // next-state and output decode
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    cap_en    = 1'b0;
    cpu_stall = 1'b0;
    rd_fwd    = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = addr_q;
    mem_wdata = wdata_q;
    line_set  = 1'b0;
    line_idx  = idx_q;
    line_tag  = tag_q;
    dw_en     = 1'b0;
    dw_idx    = idx_q;
    dw_off    = off_q;
    dw_data   = wdata_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cpu_wr) begin
          // store goes out at once, independent of the tag compare
          cap_en    = 1'b1;
          cnt_d     = '0;
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = cpu_addr;
          mem_wdata = cpu_wdata;
          if (mem_ack && lk_hit) begin
            dw_en   = 1'b1;
            dw_idx  = cpu_idx;
            dw_off  = cpu_off;
            dw_data = cpu_wdata;
          end else if (mem_ack) begin
            cpu_stall = 1'b1;
            st_d      = ST_FILL;
          end else begin
            cpu_stall = 1'b1;
            st_d      = ST_WRITE;
          end
        end else if (cpu_rd && !lk_hit) begin
          cap_en    = 1'b1;
          cnt_d     = '0;
          cpu_stall = 1'b1;
          st_d      = ST_FILL;
        end
      end
      ST_WRITE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        cpu_stall = 1'b1;
        if (mem_ack) begin
          if (whit_q) begin
            dw_en     = 1'b1;
            cpu_stall = 1'b0;
            st_d      = ST_IDLE;
          end else begin
            st_d      = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        mem_req   = 1'b1;
        mem_addr  = {tag_q, idx_q, fill_off};
        cpu_stall = 1'b1;
        dw_off    = fill_off;
        dw_data   = mem_rdata;
        if (mem_ack) begin
          dw_en = 1'b1;
          cnt_d = cnt_q + OFF_W'(1);
          if (last_beat) begin
            line_set  = 1'b1;
            cpu_stall = 1'b0;
            rd_fwd    = 1'b1;
            st_d      = ST_IDLE;
          end
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // request capture, clock enabled, no reset
  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q  <= cpu_addr;
      wdata_q <= cpu_wdata;
      whit_q  <= lk_hit;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && (!mem_we || $stable(mem_wdata)))); // R9

  AST_STORE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && cpu_wr) |-> (mem_req && mem_we && mem_addr == cpu_addr
                                     && mem_wdata == cpu_wdata)); // R6

  AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && cpu_rd && !cpu_wr && lk_hit) |-> (!cpu_stall && !mem_req)); // R3

  AST_FILL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL && !mem_ack) |-> cpu_stall); // R4

  AST_CRITICAL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL && mem_ack && last_beat) |-> (mem_addr == addr_q && !mem_we)); // R5

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
  import dc_pkg::*;
#(
  parameter int unsigned TAG_W  = DC_TAG_W,
  parameter int unsigned IDX_W  = DC_IDX_W,
  parameter int unsigned OFF_W  = DC_OFF_W,
  parameter int unsigned DATA_W = DC_DATA_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [TAG_W+IDX_W+OFF_W-1:0] cpu_addr,
  input  logic                         cpu_rd,
  input  logic                         cpu_wr,
  input  logic [DATA_W-1:0]            cpu_wdata,
  output logic [DATA_W-1:0]            cpu_rdata,
  output logic                         cpu_stall,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [TAG_W+IDX_W+OFF_W-1:0] mem_addr,
  output logic [DATA_W-1:0]            mem_wdata,
  input  logic [DATA_W-1:0]            mem_rdata,
  input  logic                         mem_ack
);

  localparam int unsigned ADDR_W = TAG_W + IDX_W + OFF_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              lk_hit;
  logic              rd_fwd;
  logic              line_set;
  logic [IDX_W-1:0]  line_idx;
  logic [TAG_W-1:0]  line_tag;
  logic              dw_en;
  logic [IDX_W-1:0]  dw_idx;
  logic [OFF_W-1:0]  dw_off;
  logic [DATA_W-1:0] dw_data;
  logic [DATA_W-1:0] arr_rdata;

  dc_tag_store #(
    .TAG_W (TAG_W),
    .IDX_W (IDX_W)
  ) u_tags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .lk_idx  (cpu_addr[OFF_W +: IDX_W]),
    .lk_tag  (cpu_addr[ADDR_W-1 -: TAG_W]),
    .lk_hit  (lk_hit),
    .set_en  (line_set),
    .set_idx (line_idx),
    .set_tag (line_tag)
  );

  dc_data_store #(
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W)
  ) u_data (
    .clk     (clk),
    .wr_en   (dw_en),
    .wr_idx  (dw_idx),
    .wr_off  (dw_off),
    .wr_data (dw_data),
    .rd_idx  (cpu_addr[OFF_W +: IDX_W]),
    .rd_off  (cpu_addr[OFF_W-1:0]),
    .rd_data (arr_rdata)
  );

  dc_ctrl #(
    .TAG_W  (TAG_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .lk_hit    (lk_hit),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .cpu_stall (cpu_stall),
    .rd_fwd    (rd_fwd),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .line_set  (line_set),
    .line_idx  (line_idx),
    .line_tag  (line_tag),
    .dw_en     (dw_en),
    .dw_idx    (dw_idx),
    .dw_off    (dw_off),
    .dw_data   (dw_data)
  );

  // the last fill beat carries the requested word: hand it over directly
  assign cpu_rdata = rd_fwd ? mem_rdata : arr_rdata;

  AST_FWD_IS_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_fwd |-> (mem_ack && !mem_we && !cpu_stall)); // R4

endmodule

// File: tb/wt_dcache_tb.sv
module wt_dcache_tb;

  localparam int MEM_LAT = 2;

  logic        clk;
  logic        rst_n;
  logic [7:0]  cpu_addr;
  logic        cpu_rd;
  logic        cpu_wr;
  logic [31:0] cpu_wdata;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_req;
  logic        mem_we;
  logic [7:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ack;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  wt_dcache u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .cpu_stall (cpu_stall),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] init_word(input logic [7:0] a);
    return {8'hD0, a, ~a, a ^ 8'h5A};
  endfunction

  // memory model: acknowledges in the MEM_LAT-th cycle of each request
  logic [31:0] bmem [256];
  int          mcnt;
  logic [7:0]  last4 [4];

  assign mem_ack   = mem_req && (mcnt == MEM_LAT - 1);
  assign mem_rdata = bmem[mem_addr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < 256; a++) bmem[a] <= init_word(8'(a));
      mcnt <= 0;
      for (int k = 0; k < 4; k++) last4[k] <= 8'h00;
    end else if (mem_req) begin
      if (mem_ack) begin
        mcnt <= 0;
        if (mem_we) begin
          bmem[mem_addr] <= mem_wdata;
        end else begin
          last4[0] <= last4[1];
          last4[1] <= last4[2];
          last4[2] <= last4[3];
          last4[3] <= mem_addr;
        end
      end else begin
        mcnt <= mcnt + 1;
      end
    end else begin
      mcnt <= 0;
    end
  end

  // reference model of the cache contents
  bit          ref_vld [16];
  logic [1:0]  ref_tag [16];
  logic [31:0] ref_mem [256];

  function automatic bit ref_hit(input logic [7:0] a);
    return ref_vld[a[5:2]] && (ref_tag[a[5:2]] == a[7:6]);
  endfunction

  function automatic int exp_stalls(input bit is_wr, input bit hit);
    if (is_wr) return hit ? 1 : 9;
    return hit ? 0 : 8;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles at most", cyc, 100000);
      summary();
    end
  end

  // one processor access; returns stall count, read data and first-cycle request
  task automatic do_op(input bit rd, input bit wr, input logic [7:0] a, input logic [31:0] d,
                       output int stalls, output logic [31:0] rdat, output bit req0,
                       output bit launch_ok);
    @(negedge clk);
    cpu_rd    = rd;
    cpu_wr    = wr;
    cpu_addr  = a;
    cpu_wdata = d;
    stalls    = 0;
    rdat      = '0;
    #1;
    req0      = mem_req;
    launch_ok = mem_req && mem_we && (mem_addr == a) && (mem_wdata == d);
    while (1) begin
      if (!cpu_stall) begin
        rdat = cpu_rdata;
        break;
      end
      stalls++;
      if (stalls > 40) break;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    cpu_rd = 1'b0;
    cpu_wr = 1'b0;
  endtask

  // access with full checking against the reference model
  task automatic op_checked(input bit rd, input bit wr, input logic [7:0] a,
                            input logic [31:0] d, input string req);
    int          st;
    logic [31:0] rv;
    bit          r0;
    bit          lo;
    bit          hit;
    hit = ref_hit(a);
    do_op(rd, wr, a, d, st, rv, r0, lo);
    if (wr) begin
      chk(st == exp_stalls(1'b1, hit), req, "store stall cycles", 32'(st),
          32'(exp_stalls(1'b1, hit)));
      chk(lo, "R6", "store launched same cycle", {31'd0, lo}, 32'd1);
      ref_mem[a] = d;
      chk(bmem[a] == d, "R6", "memory holds stored word", bmem[a], d);
    end else begin
      chk(st == exp_stalls(1'b0, hit), req, "load stall cycles", 32'(st),
          32'(exp_stalls(1'b0, hit)));
      chk(rv == ref_mem[a], req, "load data", rv, ref_mem[a]);
      if (hit) chk(!r0, "R3", "no memory request on hit", {31'd0, r0}, 32'd0);
    end
    ref_vld[a[5:2]] = 1'b1;
    ref_tag[a[5:2]] = a[7:6];
  endtask

  initial begin
    void'($urandom(32'h1A2B3C4D));
    rst_n     = 1'b0;
    cpu_rd    = 1'b0;
    cpu_wr    = 1'b0;
    cpu_addr  = '0;
    cpu_wdata = '0;
    for (int a = 0; a < 256; a++) ref_mem[a] = init_word(8'(a));
    for (int i = 0; i < 16; i++) begin
      ref_vld[i] = 1'b0;
      ref_tag[i] = 2'd0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    // R2: idle outputs after reset
    chk(!cpu_stall, "R2", "stall after reset", {31'd0, cpu_stall}, 32'd0);
    chk(!mem_req, "R2", "mem_req after reset", {31'd0, mem_req}, 32'd0);

    // R2 / R4: first read misses
    op_checked(1'b1, 1'b0, 8'h00, 32'h0, "R4");
    // R3: same word now hits
    op_checked(1'b1, 1'b0, 8'h00, 32'h0, "R3");
    // R5: the rest of the line hits
    op_checked(1'b1, 1'b0, 8'h01, 32'h0, "R5");
    op_checked(1'b1, 1'b0, 8'h02, 32'h0, "R5");
    op_checked(1'b1, 1'b0, 8'h03, 32'h0, "R5");

    // R5: fill order for a miss at offset 2 (tag 1, index 1)
    op_checked(1'b1, 1'b0, 8'h46, 32'h0, "R4");
    chk(last4[0] == 8'h47, "R5", "fill beat 0 address", 32'(last4[0]), 32'h47);
    chk(last4[1] == 8'h44, "R5", "fill beat 1 address", 32'(last4[1]), 32'h44);
    chk(last4[2] == 8'h45, "R5", "fill beat 2 address", 32'(last4[2]), 32'h45);
    chk(last4[3] == 8'h46, "R5", "fill beat 3 address", 32'(last4[3]), 32'h46);

    // R1: same index, different tag evicts
    op_checked(1'b1, 1'b0, 8'h04, 32'h0, "R1");
    op_checked(1'b1, 1'b0, 8'h46, 32'h0, "R1");
    op_checked(1'b1, 1'b0, 8'h05, 32'h0, "R1");

    // R7: store hit then read back
    op_checked(1'b1, 1'b0, 8'h47, 32'h0, "R3");
    op_checked(1'b0, 1'b1, 8'h47, 32'hCAFE_0047, "R7");
    op_checked(1'b1, 1'b0, 8'h47, 32'h0, "R7");

    // R8: store miss, then the word and a neighbour hit
    op_checked(1'b0, 1'b1, 8'hC9, 32'hBEEF_00C9, "R8");
    op_checked(1'b1, 1'b0, 8'hC9, 32'h0, "R8");
    op_checked(1'b1, 1'b0, 8'hCB, 32'h0, "R8");

    // R10: both strobes act as a store (miss on index 4)
    op_checked(1'b1, 1'b1, 8'h10, 32'h1234_5678, "R10");
    op_checked(1'b1, 1'b0, 8'h10, 32'h0, "R10");

    // random traffic over few indices and all tags
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      logic [7:0]  a;
      bit          w;
      r = $urandom;
      a = {r[9:8], 2'b00, r[11:10], r[13:12]};
      w = (r[3:0] < 4'd5);
      if (w) op_checked(1'b0, 1'b1, a, $urandom, ref_hit(a) ? "R7" : "R8");
      else   op_checked(1'b1, 1'b0, a, 32'h0, ref_hit(a) ? "R3" : "R4");
    end

    repeat (3) @(negedge clk);
    summary();
  end

endmodule